// File: doc/BRIEF.md
# Sharing-List Coherence Controller

This block keeps the coherence bookkeeping for a single memory line shared by a small set of caching nodes. The memory side records only whether the line is cached and which node heads the list of sharers. Each node's tag entry holds a line state and two pointers, one toward the next-older sharer and one toward the next-newer sharer. Together the tags form a doubly linked list, with the newest reader at its head.

A node issues a command: a read or a purge. A read that reaches uncached memory is served from memory, and the reader becomes the only member of the list. A read that reaches cached memory gets back the identity of the current head. The memory repoints its head to the reader in that same step. The reader then prepends itself to the old head, which links back to it and hands over the data. A purge is allowed only from the head. It walks the list through the forward pointers and invalidates one member per cycle. It finishes with the head holding the line exclusive. Payloads and the network are abstracted away. A command is accepted through a valid/ready handshake and completes with a one-cycle done pulse that carries a response code.

A combinational query port exposes any node's tag entry. The memory state and memory head are driven out directly.

Top module: `sharelist_node_ctrl`

## Requirements
- R1: After reset the memory is uncached, the memory head is the null pointer (value NODES), and every line is invalid with both pointers null. `cmd_ready` is high. Line state codes are invalid 0, head 1, middle 2, tail 3 and exclusive 4.
- R2: A read that reaches uncached memory makes the requester head with null pointers. The memory becomes cached with its head set to the requester. The response code is 0 with a null `done_ptr`. `done` rises after the first rising edge following the accepting edge.
- R3: A read that reaches cached memory sets the memory head to the requester. It returns the old head in `done_ptr` with response code 1. The requester becomes head, with forward pointing to the old head and backward null. The old head's backward pointer becomes the requester. The old head becomes tail if it was alone, and middle otherwise. `done` rises after the second rising edge following acceptance.
- R4: A read from a node that already holds the line returns code 2, changes no state, and completes after the first edge following acceptance.
- R5: A purge from the head invalidates every other member and clears its pointers. The purging node becomes exclusive with null pointers, and the memory head is unchanged. The response code is 3. With k other members, `done` rises after k+2 edges following acceptance.
- R6: A purge from a node that is not head or exclusive is refused with code 4 and no state change. So is any command naming a node index of NODES or above. Both complete after the first edge following acceptance.
- R7: A read by another node while one node holds the line exclusive demotes the exclusive holder to tail. The reader is prepended as in R3.
- R8: A query for a node index of NODES or above reports state invalid and null pointers.
- R9: `cmd_ready` is low from the cycle after acceptance until the command completes. `done` is high for exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle and able to accept |
| cmd_purge | input | 1 | 1 = purge, 0 = read |
| cmd_node | input | PTR_W | Requesting node index |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 3 | Response code of the completed command |
| done_ptr | output | PTR_W | Old head returned by a cached read, else null |
| mem_cached | output | 1 | Memory directory state |
| mem_head | output | PTR_W | Memory head pointer |
| qry_node | input | PTR_W | Node index to inspect |
| qry_state | output | 3 | Line state of the queried node |
| qry_fwd | output | PTR_W | Forward pointer of the queried node |
| qry_bwd | output | PTR_W | Backward pointer of the queried node |

## Verification
The bench builds the block with NODES = 4, so pointers are 3 bits wide and the null value is 4. With only four nodes, every sequence of four commands, each drawn from the eight read-or-purge-by-node choices, can be replayed from reset: 4096 sequences in all. That sweep brings within reach lists of every length up to full occupancy, purges issued from every list position and from outside the list, and reads against an exclusive holder. After every command, each tag entry is compared against an arithmetic list model. The spare pointer codes 5 to 7 exercise out-of-range commands and queries.

// File: rtl/sharelist_node_ctrl.sv
module sharelist_node_ctrl #(
  parameter int NODES = 4,
  localparam int PTR_W = $clog2(NODES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_purge,
  input  logic [PTR_W-1:0] cmd_node,
  output logic             done,
  output logic [2:0]       done_code,
  output logic [PTR_W-1:0] done_ptr,
  output logic             mem_cached,
  output logic [PTR_W-1:0] mem_head,
  input  logic [PTR_W-1:0] qry_node,
  output logic [2:0]       qry_state,
  output logic [PTR_W-1:0] qry_fwd,
  output logic [PTR_W-1:0] qry_bwd
);
  localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1;
  localparam logic [PTR_W-1:0] NULL_PTR = PTR_W'(NODES);

  localparam logic [2:0] LS_INV  = 3'd0;
  localparam logic [2:0] LS_HEAD = 3'd1;
  localparam logic [2:0] LS_MID  = 3'd2;
  localparam logic [2:0] LS_TAIL = 3'd3;
  localparam logic [2:0] LS_EXCL = 3'd4;

  localparam logic [2:0] RC_MEMDATA  = 3'd0;
  localparam logic [2:0] RC_PREPEND  = 3'd1;
  localparam logic [2:0] RC_HIT      = 3'd2;
  localparam logic [2:0] RC_PURGED   = 3'd3;
  localparam logic [2:0] RC_REFUSED  = 3'd4;

  typedef enum logic [1:0] {PH_IDLE, PH_MEM, PH_PREP, PH_WALK} phase_t;

  phase_t                      phase;
  logic [PTR_W-1:0]            req_node, old_head, cursor;
  logic                        req_purge;
  logic [NODES-1:0][2:0]       line_st;
  logic [NODES-1:0][PTR_W-1:0] line_fwd, line_bwd;

  logic [IDX_W-1:0] ri, oi, ci, qi;
  logic             req_ok, qry_ok;

  assign ri     = req_node[IDX_W-1:0];
  assign oi     = old_head[IDX_W-1:0];
  assign ci     = cursor[IDX_W-1:0];
  assign qi     = qry_node[IDX_W-1:0];
  assign req_ok = req_node < NULL_PTR;
  assign qry_ok = qry_node < NULL_PTR;

  assign cmd_ready = (phase == PH_IDLE);
  assign qry_state = qry_ok ? line_st[qi]  : LS_INV;
  assign qry_fwd   = qry_ok ? line_fwd[qi] : NULL_PTR;
  assign qry_bwd   = qry_ok ? line_bwd[qi] : NULL_PTR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      req_node   <= NULL_PTR;
      req_purge  <= 1'b0;
      old_head   <= NULL_PTR;
      cursor     <= NULL_PTR;
      mem_cached <= 1'b0;
      mem_head   <= NULL_PTR;
      done       <= 1'b0;
      done_code  <= RC_MEMDATA;
      done_ptr   <= NULL_PTR;
      for (int i = 0; i < NODES; i++) begin
        line_st[i]  <= LS_INV;
        line_fwd[i] <= NULL_PTR;
        line_bwd[i] <= NULL_PTR;
      end
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (cmd_valid) begin
          req_node  <= cmd_node;
          req_purge <= cmd_purge;
          phase     <= PH_MEM;
        end
        PH_MEM: begin
          done_ptr <= NULL_PTR;
          if (!req_ok) begin
            done      <= 1'b1;
            done_code <= RC_REFUSED;
            phase     <= PH_IDLE;
          end else if (!req_purge) begin
            if (line_st[ri] != LS_INV) begin
              done      <= 1'b1;
              done_code <= RC_HIT;
              phase     <= PH_IDLE;
            end else if (!mem_cached) begin
              mem_cached   <= 1'b1;
              mem_head     <= req_node;
              line_st[ri]  <= LS_HEAD;
              line_fwd[ri] <= NULL_PTR;
              line_bwd[ri] <= NULL_PTR;
              done         <= 1'b1;
              done_code    <= RC_MEMDATA;
              phase        <= PH_IDLE;
            end else begin
              old_head <= mem_head;
              mem_head <= req_node;
              phase    <= PH_PREP;
            end
          end else if (line_st[ri] == LS_HEAD || line_st[ri] == LS_EXCL) begin
            cursor <= line_fwd[ri];
            phase  <= PH_WALK;
          end else begin
            done      <= 1'b1;
            done_code <= RC_REFUSED;
            phase     <= PH_IDLE;
          end
        end
        PH_PREP: begin
          if (line_st[oi] != LS_INV) begin
            line_bwd[oi] <= req_node;
            line_st[oi]  <= (line_fwd[oi] == NULL_PTR) ? LS_TAIL : LS_MID;
            line_fwd[ri] <= old_head;
          end else begin
            line_fwd[ri] <= NULL_PTR;
          end
          line_st[ri]  <= LS_HEAD;
          line_bwd[ri] <= NULL_PTR;
          done         <= 1'b1;
          done_code    <= RC_PREPEND;
          done_ptr     <= old_head;
          phase        <= PH_IDLE;
        end
        PH_WALK: begin
          if (cursor == NULL_PTR || line_st[ci] == LS_INV) begin
            line_st[ri]  <= LS_EXCL;
            line_fwd[ri] <= NULL_PTR;
            done         <= 1'b1;
            done_code    <= RC_PURGED;
            phase        <= PH_IDLE;
          end else begin
            line_st[ci]  <= LS_INV;
            line_fwd[ci] <= NULL_PTR;
            line_bwd[ci] <= NULL_PTR;
            cursor       <= line_fwd[ci];
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

module sharelist_node_ctrl_chk #(
  parameter int NODES = 4,
  localparam int PTR_W = $clog2(NODES + 1)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cmd_valid,
  input logic                        cmd_ready,
  input logic                        done,
  input logic                        mem_cached,
  input logic [PTR_W-1:0]            mem_head,
  input logic [NODES-1:0][2:0]       line_st,
  input logic [NODES-1:0][PTR_W-1:0] line_fwd,
  input logic [NODES-1:0][PTR_W-1:0] line_bwd
);
  localparam logic [PTR_W-1:0] NULL_PTR = PTR_W'(NODES);

  logic [NODES-1:0] lead_mask;
  for (genvar g = 0; g < NODES; g++) begin : g_node
    assign lead_mask[g] = (line_st[g] == 3'd1) || (line_st[g] == 3'd4);

    AST_INVALID_UNLINKED: assert property (@(posedge clk) disable iff (!rst_n)
      line_st[g] == 3'd0 |-> line_fwd[g] == NULL_PTR && line_bwd[g] == NULL_PTR); // R5
    AST_EXCL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      line_st[g] == 3'd4 |-> line_fwd[g] == NULL_PTR && line_bwd[g] == NULL_PTR); // R5
    AST_LEAD_NO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      lead_mask[g] |-> line_bwd[g] == NULL_PTR); // R3
  end

  AST_CACHED_HAS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cached == (mem_head != NULL_PTR)); // R2
  AST_SINGLE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lead_mask) <= 1); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready); // R9
endmodule

bind sharelist_node_ctrl sharelist_node_ctrl_chk #(.NODES(NODES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .done(done), .mem_cached(mem_cached), .mem_head(mem_head),
  .line_st(line_st), .line_fwd(line_fwd), .line_bwd(line_bwd)
);

// File: tb/sharelist_node_ctrl_test.sv
`timescale 1ns/1ps
module sharelist_node_ctrl_test;
  localparam int NODES = 4;
  localparam int PTR_W = 3;
  localparam int NUL = NODES;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic             cmd_purge = 1'b0;
  logic [PTR_W-1:0] cmd_node = '0;
  logic             done;
  logic [2:0]       done_code;
  logic [PTR_W-1:0] done_ptr;
  logic             mem_cached;
  logic [PTR_W-1:0] mem_head;
  logic [PTR_W-1:0] qry_node = '0;
  logic [2:0]       qry_state;
  logic [PTR_W-1:0] qry_fwd, qry_bwd;

  int checks = 0;
  int errors = 0;
  int lst[NODES];
  int len = 0;
  bit excl = 1'b0;

  always #10 clk = ~clk;

  sharelist_node_ctrl #(.NODES(NODES)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_purge(cmd_purge), .cmd_node(cmd_node), .done(done), .done_code(done_code),
    .done_ptr(done_ptr), .mem_cached(mem_cached), .mem_head(mem_head),
    .qry_node(qry_node), .qry_state(qry_state), .qry_fwd(qry_fwd), .qry_bwd(qry_bwd)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int find(int n);
    for (int i = 0; i < len; i++) if (lst[i] == n) return i;
    return -1;
  endfunction

  task automatic check_all(string tag);
    chk(tag, "mem_cached", int'(mem_cached), (len > 0) ? 1 : 0);
    chk(tag, "mem_head", int'(mem_head), (len > 0) ? lst[0] : NUL);
    for (int i = 0; i < NODES; i++) begin
      int p, es, ef, eb;
      qry_node = PTR_W'(i);
      #1;
      p  = find(i);
      es = (p < 0) ? 0 : (p == 0) ? (excl ? 4 : 1) : (p == len - 1) ? 3 : 2;
      ef = (p >= 0 && p < len - 1) ? lst[p + 1] : NUL;
      eb = (p > 0) ? lst[p - 1] : NUL;
      chk(tag, "line state", int'(qry_state), es);
      chk(tag, "fwd ptr", int'(qry_fwd), ef);
      chk(tag, "bwd ptr", int'(qry_bwd), eb);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    len = 0;
    excl = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_op(bit p, int n);
    int ecode, elat, eptr, lat;
    string tag;
    eptr = NUL;
    if (n >= NODES) begin
      ecode = 4; elat = 2; tag = "R6";
    end else if (!p) begin
      if (find(n) >= 0) begin
        ecode = 2; elat = 2; tag = "R4";
      end else if (len == 0) begin
        ecode = 0; elat = 2; tag = "R2";
        lst[0] = n; len = 1;
      end else begin
        ecode = 1; elat = 3; eptr = lst[0];
        tag = excl ? "R7" : "R3";
        for (int i = NODES - 1; i > 0; i--) lst[i] = lst[i - 1];
        lst[0] = n; len++; excl = 1'b0;
      end
    end else if (len > 0 && lst[0] == n) begin
      ecode = 3; elat = len + 2; tag = "R5";
      len = 1; excl = 1'b1;
    end else begin
      ecode = 4; elat = 2; tag = "R6";
    end

    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_purge = p;
    cmd_node  = PTR_W'(n);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    chk("R9", "ready while busy", int'(cmd_ready), 0);
    while (!done && lat < 40) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    chk(tag, "latency", lat, elat);
    chk(tag, "done_code", int'(done_code), ecode);
    chk(tag, "done_ptr", int'(done_ptr), eptr);
    check_all(tag);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "done width", int'(done), 0);
    chk("R9", "ready after done", int'(cmd_ready), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1", "cmd_ready", int'(cmd_ready), 1);
    check_all("R1");

    for (int s = 0; s < 4096; s++) begin
      do_reset();
      chk("R1", "reset mem_cached", int'(mem_cached), 0);
      for (int j = 0; j < 4; j++) begin
        int op;
        op = (s >> (3 * j)) & 7;
        do_op(op[2], op & 3);
      end
    end

    do_reset();
    do_op(1'b0, 2);
    do_op(1'b0, 0);
    do_op(1'b0, 5);
    do_op(1'b1, 6);
    for (int q = NODES; q < 8; q++) begin
      qry_node = PTR_W'(q);
      #1;
      chk("R8", "oob state", int'(qry_state), 0);
      chk("R8", "oob fwd", int'(qry_fwd), NUL);
      chk("R8", "oob bwd", int'(qry_bwd), NUL);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule